// File: doc/BRIEF.md
# Byte-Stream Program Memory Loader

After reset, this block fills a 24-bit-wide program RAM from a byte-wide source. On the first clock after reset is released, it captures a 4-bit mode input. If the mode is a normal-run code, the block goes straight to run and loads nothing. If the mode is a loading code, the block accepts bytes over a valid/ready handshake and packs them into 24-bit fields. Each field is made from three bytes, and the lowest byte comes first.

The first field is the number of words to load. The second field is the RAM address where loading begins. Every later field is one program word. The block writes each word through a one-cycle write port, at rising consecutive addresses. When the last word is written, the block presents the start address and pulses a jump strobe. In the host-flag modes, a stop input ends the payload early and causes the same jump.

The controller has seven states:
- ST_SAMPLE captures the mode.
- ST_COUNT, ST_ADDR and ST_DATA take in the three kinds of field.
- ST_JUMP pulses the strobe.
- ST_DONE is the state after a load.
- ST_RUN is the normal-run state.

Its transitions are:
- sample-to-count for a load mode.
- sample-to-run for a normal mode.
- count-to-addr when the count field is complete.
- addr-to-data when the address field is complete and the count is not zero.
- addr-to-jump when the count is zero.
- data-to-jump on the last word or on a host stop.
- jump-to-done unconditionally.

Top module: `bootldr_top`

## Requirements
- R1: `op_mode` takes the value of `mode_pins` at the first rising clock edge after `rst_n` goes high. It then holds that value until the next reset.
- R2: Only mode values 9, 10 and 12 to 15 start a load. Every other value makes `cpu_run` rise one cycle after reset release. In a normal mode, `byte_ready`, `mem_we` and `jump_strobe` all stay low.
- R3: A byte is taken on a rising edge where `byte_valid` and `byte_ready` are both high. Three taken bytes form one 24-bit field. The first byte fills bits 7:0, the second bits 15:8 and the third bits 23:16.
- R4: The first field of the stream is the word count. The second field is the start address.
- R5: For payload word k (counting from 0), `mem_we` is high for exactly one cycle. That cycle is the cycle after the word's third byte is taken. During it, `mem_addr` equals start+k and `mem_wdata` equals the word.
- R6: After the counted number of words, `jump_strobe` is high for exactly one cycle, in the same cycle as the last write. In that cycle `jump_addr` equals the start address. From the next cycle on, `cpu_run` is high.
- R7: A count of zero makes `jump_strobe` pulse in the cycle after the sixth header byte is taken. No write takes place.
- R8: In modes 12 to 15, `host_stop` high during the payload drops `byte_ready` in the same cycle. The jump to the start address then follows one cycle later, and only the words already completed have been written. In modes 9 and 10, `host_stop` has no effect.
- R9: After the jump strobe, `byte_ready` stays low until the next reset.
- R10: While `rst_n` is low, `byte_ready`, `mem_we`, `jump_strobe`, `load_active` and `cpu_run` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 4 | Mode code, captured once after reset release |
| host_stop | input | 1 | Early-end request for the host-flag modes |
| byte_data | input | 8 | Incoming stream byte |
| byte_valid | input | 1 | Stream byte is present |
| byte_ready | output | 1 | Block will take a byte this cycle |
| mem_we | output | 1 | Program RAM write enable |
| mem_addr | output | 24 | Program RAM write address |
| mem_wdata | output | 24 | Program RAM write data |
| jump_strobe | output | 1 | One-cycle pulse handing control to the start address |
| jump_addr | output | 24 | Start address taken from the header |
| op_mode | output | 4 | Captured mode code |
| load_active | output | 1 | Loading (from the count field up to the jump) |
| cpu_run | output | 1 | Normal run, or a load has completed |

## Verification
The most visible failure is a packer whose byte position has drifted. It shows up as rotated write data in the first payload word, three taken bytes after the header. A wrong remaining-word count shows up in the cycle where the last write is due: the jump strobe appears a word too early or too late, and the write count is off by one. A bad mode decode shows within one cycle of reset release: `cpu_run` or `load_active` has the wrong value, or `byte_ready` has the wrong level.

// File: rtl/bootldr_pkg.sv
package bootldr_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_JUMP,
        ST_DONE,
        ST_RUN
    } ldr_state_t;

    // Mode codes that start a load: 9, 10, 12..15
    function automatic logic is_load_mode(input logic [3:0] m);
        return (m == 4'd9) || (m == 4'd10) || (m >= 4'd12);
    endfunction

    // Mode codes in which the host stop flag is honoured: 12..15
    function automatic logic is_host_mode(input logic [3:0] m);
        return (m >= 4'd12);
    endfunction

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [MODE_W-1:0] mode_pins,
    output logic [MODE_W-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (sample)
            mode_q <= mode_pins;
    end

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_done,
    output logic [WORD_W-1:0] word_out
);

    localparam int NB     = WORD_W / BYTE_W;
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1;
    localparam int HOLD_W = WORD_W - BYTE_W;

    logic [IDX_W-1:0]  idx_q;
    logic [HOLD_W-1:0] hold_q;
    logic              last_lane;

    assign last_lane = (idx_q == IDX_W'(NB - 1));
    assign word_done = take && last_lane;
    assign word_out  = {byte_in, hold_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (take)
            idx_q <= last_lane ? '0 : idx_q + 1'b1;
    end

    // one lane register per non-final byte position
    for (genvar g = 0; g < NB - 1; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hold_q[g*BYTE_W +: BYTE_W] <= '0;
            else if (take && idx_q == IDX_W'(g))
                hold_q[g*BYTE_W +: BYTE_W] <= byte_in;
        end
    end

endmodule

// File: rtl/prog_write_port.sv
module prog_write_port #(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    logic [ADDR_W-1:0] next_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_addr_q <= '0;
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
        end else begin
            mem_we <= word_valid;
            if (load_base)
                next_addr_q <= base_addr;
            else if (word_valid) begin
                mem_addr    <= next_addr_q;
                mem_wdata   <= word;
                next_addr_q <= next_addr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bootldr_top.sv
module bootldr_top
    import bootldr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 24,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              host_stop,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    output logic              byte_ready,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              jump_strobe,
    output logic [WORD_W-1:0] jump_addr,
    output logic [MODE_W-1:0] op_mode,
    output logic              load_active,
    output logic              cpu_run
);

    ldr_state_t        st_q, st_d;
    logic              take, word_done, stop_now, sample;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] count_q, start_q, remain_q;

    assign sample   = (st_q == ST_SAMPLE);
    assign stop_now = (st_q == ST_DATA) && host_stop && is_host_mode(4'(op_mode));
    assign take     = byte_valid && byte_ready;

    boot_mode_latch #(.MODE_W(MODE_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .mode_pins(mode_pins),
        .mode_q   (op_mode)
    );

    byte_word_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .byte_in  (byte_data),
        .word_done(word_done),
        .word_out (word)
    );

    prog_write_port #(.ADDR_W(WORD_W), .WORD_W(WORD_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (st_q == ST_ADDR && word_done),
        .base_addr (word),
        .word_valid(st_q == ST_DATA && word_done),
        .word      (word),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_SAMPLE;
        else
            st_q <= st_d;
    end

    // header fields and remaining-word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            start_q  <= '0;
            remain_q <= '0;
        end else begin
            if (st_q == ST_COUNT && word_done)
                count_q <= word;
            if (st_q == ST_ADDR && word_done) begin
                start_q  <= word;
                remain_q <= count_q;
            end
            if (st_q == ST_DATA && word_done)
                remain_q <= remain_q - 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SAMPLE: st_d = is_load_mode(4'(mode_pins)) ? ST_COUNT : ST_RUN;
            ST_COUNT:  if (word_done) st_d = ST_ADDR;
            ST_ADDR:   if (word_done) st_d = (count_q == '0) ? ST_JUMP : ST_DATA;
            ST_DATA: begin
                if (stop_now)
                    st_d = ST_JUMP;
                else if (word_done && remain_q == WORD_W'(1))
                    st_d = ST_JUMP;
            end
            ST_JUMP:   st_d = ST_DONE;
            ST_DONE:   st_d = ST_DONE;
            ST_RUN:    st_d = ST_RUN;
            default:   st_d = ST_SAMPLE;
        endcase
    end

    // outputs
    always_comb begin
        byte_ready  = 1'b0;
        jump_strobe = 1'b0;
        load_active = 1'b0;
        cpu_run     = 1'b0;
        unique case (st_q)
            ST_SAMPLE: ;
            ST_COUNT, ST_ADDR: begin
                byte_ready  = 1'b1;
                load_active = 1'b1;
            end
            ST_DATA: begin
                byte_ready  = !stop_now;
                load_active = 1'b1;
            end
            ST_JUMP: begin
                jump_strobe = 1'b1;
                load_active = 1'b1;
            end
            ST_DONE, ST_RUN: cpu_run = 1'b1;
            default: ;
        endcase
    end

    assign jump_addr = start_q;

endmodule

// File: rtl/bootldr_checker.sv
module bootldr_checker #(
    parameter int WORD_W = 24,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_ready,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              jump_strobe,
    input logic [MODE_W-1:0] op_mode,
    input logic              load_active,
    input logic              cpu_run
);

    logic              have_prev;
    logic [WORD_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (mem_we) begin
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |-> (!byte_ready && !mem_we && !jump_strobe && !load_active && !cpu_run));

    assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active || cpu_run) |=> $stable(op_mode));

    assert_run_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> (!mem_we && !byte_ready));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && have_prev) |-> (mem_addr == prev_addr + 1'b1));

    assert_jump_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        jump_strobe |=> (!jump_strobe && cpu_run));

    assert_ready_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jump_strobe |=> !byte_ready);

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_active && cpu_run));

endmodule

bind bootldr_top bootldr_checker #(.WORD_W(WORD_W), .MODE_W(MODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_ready (byte_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .jump_strobe(jump_strobe),
    .op_mode    (op_mode),
    .load_active(load_active),
    .cpu_run    (cpu_run)
);

// File: tb/bootldr_top_tb_top.sv
`timescale 1ns/1ps
module bootldr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_pins = '0;
    logic        host_stop = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_valid = 1'b0;
    logic        byte_ready, mem_we, jump_strobe, load_active, cpu_run;
    logic [23:0] mem_addr, mem_wdata, jump_addr;
    logic [3:0]  op_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [23:0] wa [0:63];
    logic [23:0] wd [0:63];
    int          nwr = 0;
    int          njump = 0;
    logic [23:0] jaddr = '0;
    logic [23:0] wbuf [0:31];

    always #2 clk = ~clk;

    bootldr_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .host_stop(host_stop),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .jump_strobe(jump_strobe), .jump_addr(jump_addr), .op_mode(op_mode),
        .load_active(load_active), .cpu_run(cpu_run)
    );

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && mem_we) begin
            if (nwr < 64) begin
                wa[nwr] = mem_addr;
                wd[nwr] = mem_wdata;
            end
            nwr = nwr + 1;
        end
        if (rst_n && jump_strobe) begin
            njump = njump + 1;
            jaddr = jump_addr;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit exp_load(input logic [3:0] m);
        return (m == 4'd9) || (m == 4'd10) || (m >= 4'd12);
    endfunction

    function automatic bit exp_host(input logic [3:0] m);
        return (m >= 4'd12);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        byte_valid = 1'b0;
        host_stop = 1'b0;
        mode_pins = m;
        repeat (2) @(negedge clk);
        nwr = 0;
        njump = 0;
        check(!byte_ready && !mem_we && !jump_strobe && !load_active && !cpu_run, "R10 reset outputs",
              {27'd0, byte_ready, mem_we, jump_strobe, load_active, cpu_run}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mode_pins = ~m;                       // later pin changes must not matter
        check(op_mode == m, "R1 captured mode", op_mode, m);
    endtask

    task automatic send_byte(input logic [7:0] b);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        byte_data = b;
        byte_valid = 1'b1;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data = $urandom();
    endtask

    task automatic send_field(input logic [23:0] v);
        send_byte(v[7:0]);
        send_byte(v[15:8]);
        send_byte(v[23:16]);
    endtask

    // stop_at < 0: no host stop; otherwise raise host_stop after stop_at words
    task automatic run_load(input logic [3:0] m, input int cnt, input logic [23:0] start, input int stop_at);
        int exp_n;
        for (int i = 0; i < cnt; i++) wbuf[i] = $urandom();
        do_reset(m);
        check(load_active == 1'b1, "R2 load mode active", load_active, 1);
        send_field(24'(cnt));
        send_field(start);
        exp_n = cnt;
        for (int i = 0; i < cnt; i++) begin
            if (i == stop_at) begin
                host_stop = 1'b1;
                #0.5;
                if (exp_host(m)) begin
                    check(!byte_ready, "R8 ready drops on stop", byte_ready, 0);
                    @(negedge clk);
                    check(jump_strobe, "R8 jump after stop", jump_strobe, 1);
                    host_stop = 1'b0;
                    exp_n = i;
                    break;
                end else begin
                    check(byte_ready, "R8 stop ignored in mode 9/10", byte_ready, 1);
                    @(negedge clk);
                    host_stop = 1'b0;
                end
            end
            send_field(wbuf[i]);
        end
        repeat (4) @(negedge clk);
        check(nwr == exp_n, "R5 write count", nwr, exp_n);
        for (int i = 0; i < exp_n && i < nwr; i++) begin
            check(wa[i] == start + 24'(i), "R5 write address", wa[i], start + 24'(i));
            check(wd[i] == wbuf[i], "R3 R4 write data", wd[i], wbuf[i]);
        end
        check(njump == 1, "R6 single jump", njump, 1);
        check(jaddr == start, "R6 jump address", jaddr, start);
        check(cpu_run && !load_active, "R6 run after jump", {cpu_run, load_active}, 2'b10);
        byte_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(!byte_ready, "R9 ready closed after jump", byte_ready, 0);
        byte_valid = 1'b0;
        check(nwr == exp_n, "R9 no extra writes", nwr, exp_n);
    endtask

    initial begin
        int seed;
        seed = $urandom(20240611);

        // every mode: decode check
        for (int m = 0; m < 16; m++) begin
            do_reset(4'(m));
            if (!exp_load(4'(m))) begin
                byte_valid = 1'b1;
                byte_data = 8'h5A;
                repeat (6) @(negedge clk);
                check(cpu_run && !byte_ready && !load_active, "R2 normal mode runs",
                      {cpu_run, byte_ready, load_active}, 3'b100);
                check(nwr == 0 && njump == 0, "R2 normal mode no writes", nwr + njump, 0);
                byte_valid = 1'b0;
            end else begin
                check(load_active && byte_ready && !cpu_run, "R2 load mode entered",
                      {load_active, byte_ready, cpu_run}, 3'b110);
            end
        end

        // directed: known byte order
        wbuf[0] = 24'h000000;
        do_reset(4'd9);
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h34); send_byte(8'h12); send_byte(8'h00);
        send_byte(8'hCC); send_byte(8'hBB); send_byte(8'hAA);
        repeat (3) @(negedge clk);
        check(nwr == 1 && wa[0] == 24'h001234, "R4 start address LSB first", wa[0], 24'h001234);
        check(wd[0] == 24'hAABBCC, "R3 byte order", wd[0], 24'hAABBCC);
        check(jaddr == 24'h001234, "R6 jump address directed", jaddr, 24'h001234);

        // directed: zero count
        run_load(4'd12, 0, 24'h00ABCD, -1);
        check(nwr == 0, "R7 zero count no write", nwr, 0);

        // directed: host stop in host mode and ignored in mode 10
        run_load(4'd13, 5, 24'h000100, 2);
        run_load(4'd10, 4, 24'h000200, 1);
        run_load(4'd15, 3, 24'h000300, 0);

        // address wrap
        run_load(4'd14, 3, 24'hFFFFFF, -1);

        // constrained random
        for (int it = 0; it < 12; it++) begin
            logic [3:0] m;
            int cnt, stp;
            case ($urandom_range(0, 5))
                0: m = 4'd9;
                1: m = 4'd10;
                default: m = 4'(12 + $urandom_range(0, 3));
            endcase
            cnt = $urandom_range(0, 20);
            stp = ($urandom_range(0, 3) == 0 && cnt > 0) ? $urandom_range(0, cnt - 1) : -1;
            run_load(m, cnt, 24'($urandom()), stp);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule